// File: doc/BRIEF.md
# General-Purpose Timer Channel

One timer channel with an up-counter, an 8-bit prescaler, a reference (compare) register, an input-capture register and one output pin. A single mode word sets how the channel runs. It chooses one of four count sources: the bus clock, the bus clock divided by a fixed ratio, falling edges on the external input, or tick pulses from a partner channel. It also sets the capture edge, pulse or toggle output, free-run or restart at the reference, and optional gating.

Software reaches the channel through a small synchronous register port. A write is taken on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The word addresses are:
- 0: mode
- 1: reference
- 2: capture (read-only)
- 3: counter (read-only)
- 4: event (write 1 to clear)
- 5: control

The external input and the gate pin are synchronized into the system clock domain. All counting uses single-cycle enables; the channel creates no derived clocks.

Top module: `gpt_channel`

## Requirements
- R1: After reset, every register reads 0, `tout_o` is 1, and `irq_o` and `casc_o` are 0.
- R2: The mode word maps as follows: [15:8] prescaler, [7:6] capture edge, [5] output toggle, [4] reference interrupt enable, [3] restart, [2:1] clock select, [0] gate enable. Mode and reference read back as written.
- R3: The counter advances by one on every (prescaler+1)-th source tick. A prescaler of 0 advances it on every tick.
- R4: Clock select picks the source tick: 00 = `casc_i` pulses (no ticks when the channel has no partner), 01 = every bus cycle, 10 = every DIV-th bus cycle, 11 = falling edges of `tin_i`.
- R5: A reference hit occurs only on an increment whose new value equals the reference register. Each hit sets event bit 0.
- R6: With restart set, the counter loads 0 on the hitting increment. With restart clear, the counter keeps counting past the reference.
- R7: With the toggle bit clear, `tout_o` goes low after a hit and returns high at the next source tick. With the toggle bit set, `tout_o` inverts on each hit.
- R8: Capture edge 01 captures on rising `tin_i` edges, 10 on falling edges, 11 on both, and 00 never. A capture copies the counter into the capture register and sets event bit 1.
- R9: `irq_o` = (event bit 0 AND reference interrupt enable) OR (event bit 1 AND capture edge not 00). Writing 1 to an event bit clears it.
- R10: With gate enable set, the counter advances only while `gate_n_i` is low. With gate enable clear, `gate_n_i` has no effect.
- R11: Control bit 0 enables counting. Writing 1 to control bit 1 clears the counter, the prescaler, the divider and the output state.
- R12: `casc_o` is high for one cycle after each reference hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| tin_i | input | 1 | External input: clock source and capture trigger |
| gate_n_i | input | 1 | Active-low gate input |
| casc_i | input | 1 | Tick pulses from the partner channel |
| tout_o | output | 1 | Timer output pin |
| casc_o | output | 1 | Reference-hit pulse to a partner channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its defaults:
- a 16-bit counter and 8-bit prescaler;
- a divide-by-16 source;
- two synchronizer stages;
- a partner present.

Because a partner is present, the cascade source can be driven directly from `casc_i`. That lets the bench step the counter to exact values before capture. The divide-by-16 ratio keeps the divided source's second increment within 32 cycles. Small reference values put restart, free-run, pulse and toggle behaviour within a few cycles of enable.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int CNT_W  = 16;
    localparam int PS_W   = 8;
    localparam int ADDR_W = 3;

    typedef struct packed {
        logic [PS_W-1:0] presc;
        logic [1:0]      cap_edge;
        logic            out_tgl;
        logic            ref_irq_en;
        logic            restart;
        logic [1:0]      clk_sel;
        logic            gate_en;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_CASC = 2'b00,
        SRC_BUS  = 2'b01,
        SRC_DIV  = 2'b10,
        SRC_PIN  = 2'b11
    } src_e;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int STAGES = 2,
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{INIT}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpt_tick_src.sv
module gpt_tick_src
    import gpt_pkg::*;
#(
    parameter int DIV         = 16,
    parameter int HAS_PARTNER = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       pin_fall,
    input  logic       casc_i,
    output logic       tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    typedef struct packed {
        logic [DW-1:0] div;
    } st_t;

    st_t s_d, s_q;
    logic div_tick;
    logic casc_tick;

    generate
        if (HAS_PARTNER != 0) begin : g_partner
            assign casc_tick = casc_i;
        end else begin : g_alone
            assign casc_tick = casc_i & 1'b0;
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        div_tick = (s_q.div == DIV_LAST);
        if (clr)           s_d.div = '0;
        else if (div_tick) s_d.div = '0;
        else               s_d.div = s_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (src_e'(sel))
            SRC_CASC: tick = casc_tick;
            SRC_BUS:  tick = 1'b1;
            SRC_DIV:  tick = div_tick;
            SRC_PIN:  tick = pin_fall;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core
    import gpt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [PW-1:0] presc,
    input  logic [CW-1:0] ref_val,
    input  logic          restart,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    typedef struct packed {
        logic [PW-1:0] ps;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0] inc;

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        inc = s_q.cnt + 1'b1;
        if (clr) begin
            s_d.ps  = '0;
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.ps >= presc) begin
                s_d.ps  = '0;
                hit     = (inc == ref_val);
                s_d.cnt = (hit && restart) ? '0 : inc;
            end else begin
                s_d.ps = s_q.ps + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && restart) |=> (cnt == '0));

    // R5
    hit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((cnt == '0) || (cnt == $past(ref_val))));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0)));
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int DIV         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HAS_PARTNER = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              tin_i,
    input  logic              gate_n_i,
    input  logic              casc_i,
    output logic              tout_o,
    output logic              casc_o,
    output logic              irq_o
);
    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] refv;
        logic [CNT_W-1:0] cap;
        logic [1:0]       evt;
        logic             en;
        logic             tog;
        logic             pulse;
        logic             hit;
        logic             tin_prev;
    } st_t;

    st_t s_d, s_q;

    logic             tin_s, gate_s;
    logic             tin_rise, tin_fall;
    logic             src_tick, cnt_tick, hit;
    logic             clr_tmr, cap_hit;
    logic [CNT_W-1:0] cnt;

    gpt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_tin_sync (
        .clk(clk), .rst_n(rst_n), .din(tin_i), .dout(tin_s));

    gpt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_gate_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_n_i), .dout(gate_s));

    assign tin_rise = tin_s & ~s_q.tin_prev;
    assign tin_fall = ~tin_s & s_q.tin_prev;
    assign clr_tmr  = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];

    gpt_tick_src #(.DIV(DIV), .HAS_PARTNER(HAS_PARTNER)) i_src (
        .clk(clk), .rst_n(rst_n), .clr(clr_tmr), .sel(s_q.mode.clk_sel),
        .pin_fall(tin_fall), .casc_i(casc_i), .tick(src_tick));

    assign cnt_tick = s_q.en && src_tick && (!s_q.mode.gate_en || !gate_s);

    gpt_count_core #(.CW(CNT_W), .PW(PS_W)) i_core (
        .clk(clk), .rst_n(rst_n), .clr(clr_tmr), .tick(cnt_tick),
        .presc(s_q.mode.presc), .ref_val(s_q.refv), .restart(s_q.mode.restart),
        .cnt(cnt), .hit(hit));

    always_comb begin
        unique case (s_q.mode.cap_edge)
            2'b01:   cap_hit = tin_rise;
            2'b10:   cap_hit = tin_fall;
            2'b11:   cap_hit = tin_rise | tin_fall;
            default: cap_hit = 1'b0;
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.tin_prev = tin_s;
        s_d.hit      = hit;
        if (reg_wr) begin
            unique case (reg_addr)
                A_MODE:  s_d.mode = mode_t'(reg_wdata);
                A_REF:   s_d.refv = reg_wdata;
                A_EVT:   s_d.evt  = s_q.evt & ~reg_wdata[1:0];
                A_CTRL:  s_d.en   = reg_wdata[0];
                default: ;
            endcase
        end
        if (cap_hit) begin
            s_d.cap    = cnt;
            s_d.evt[1] = 1'b1;
        end
        if (hit) s_d.evt[0] = 1'b1;
        if (clr_tmr) begin
            s_d.tog   = 1'b0;
            s_d.pulse = 1'b0;
        end else if (hit) begin
            if (s_q.mode.out_tgl) s_d.tog   = ~s_q.tog;
            else                  s_d.pulse = 1'b1;
        end else if (src_tick) begin
            s_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_addr)
            A_MODE:  reg_rdata = s_q.mode;
            A_REF:   reg_rdata = s_q.refv;
            A_CAP:   reg_rdata = s_q.cap;
            A_CNT:   reg_rdata = cnt;
            A_EVT:   reg_rdata = {{(CNT_W-2){1'b0}}, s_q.evt};
            A_CTRL:  reg_rdata = {{(CNT_W-1){1'b0}}, s_q.en};
            default: reg_rdata = '0;
        endcase
    end

    assign tout_o = s_q.mode.out_tgl ? s_q.tog : ~s_q.pulse;
    assign casc_o = s_q.hit;
    assign irq_o  = (s_q.evt[0] & s_q.mode.ref_irq_en) |
                    (s_q.evt[1] & (s_q.mode.cap_edge != 2'b00));

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode.gate_en && gate_s && !clr_tmr) |=> $stable(cnt));

    // R8
    cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode.cap_edge == 2'b00) |=> $stable(s_q.cap));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (s_q.evt != 2'b00));
endmodule

// File: tb/test_gpt_channel.sv
module test_gpt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        tin_i = 1'b1;
    logic        gate_n_i = 1'b1;
    logic        casc_i = 1'b0;
    logic        tout_o, casc_o, irq_o;
    int          n_vec = 0;
    int          n_bad = 0;

    localparam logic [2:0] MODE = 3'd0, REFR = 3'd1, CAP = 3'd2, CNT = 3'd3, EVT = 3'd4, CTRL = 3'd5;

    gpt_channel i_gpt_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tin_i(tin_i),
        .gate_n_i(gate_n_i), .casc_i(casc_i), .tout_o(tout_o),
        .casc_o(casc_o), .irq_o(irq_o));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic casc_pulse();
        casc_i = 1'b1; step(1); casc_i = 1'b0; step(1);
    endtask

    task automatic t_reset();
        rdchk("R1 mode", MODE, 16'h0); rdchk("R1 ref", REFR, 16'h0);
        rdchk("R1 cap", CAP, 16'h0);   rdchk("R1 cnt", CNT, 16'h0);
        rdchk("R1 evt", EVT, 16'h0);   rdchk("R1 ctrl", CTRL, 16'h0);
        chk("R1 tout", {15'd0, tout_o}, 16'd1);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        chk("R1 casc", {15'd0, casc_o}, 16'd0);
    endtask

    task automatic t_prescale();
        wr(CTRL, 16'h2); wr(MODE, 16'h0302); wr(REFR, 16'h1234);
        rdchk("R2 mode readback", MODE, 16'h0302);
        rdchk("R2 ref readback", REFR, 16'h1234);
        wr(CTRL, 16'h1);
        step(7); rdchk("R3 after 7 ticks", CNT, 16'd1);
        step(1); rdchk("R3 after 8 ticks", CNT, 16'd2);
    endtask

    task automatic t_restart();
        wr(CTRL, 16'h2); wr(EVT, 16'h3); wr(REFR, 16'd5); wr(MODE, 16'h001A); wr(CTRL, 16'h1);
        step(4); rdchk("R5 before hit", CNT, 16'd4); rdchk("R5 no flag", EVT, 16'd0);
        chk("R7 tout idle", {15'd0, tout_o}, 16'd1);
        step(1); rdchk("R6 restart to 0", CNT, 16'd0); rdchk("R5 flag set", EVT, 16'd1);
        chk("R12 casc pulse", {15'd0, casc_o}, 16'd1);
        chk("R7 pulse low", {15'd0, tout_o}, 16'd0);
        chk("R9 ref irq", {15'd0, irq_o}, 16'd1);
        step(1); rdchk("R6 counts on", CNT, 16'd1);
        chk("R12 casc one cycle", {15'd0, casc_o}, 16'd0);
        chk("R7 pulse ends", {15'd0, tout_o}, 16'd1);
    endtask

    task automatic t_freerun();
        wr(CTRL, 16'h2); wr(EVT, 16'h3); wr(REFR, 16'd3); wr(MODE, 16'h0022); wr(CTRL, 16'h1);
        step(2); chk("R7 toggle start", {15'd0, tout_o}, 16'd0);
        step(1); rdchk("R6 free-run at ref", CNT, 16'd3);
        chk("R7 toggled", {15'd0, tout_o}, 16'd1);
        chk("R9 ref irq masked", {15'd0, irq_o}, 16'd0);
        step(1); rdchk("R6 free-run past ref", CNT, 16'd4);
        chk("R7 toggle holds", {15'd0, tout_o}, 16'd1);
        wr(EVT, 16'h1); rdchk("R9 w1c", EVT, 16'd0);
    endtask

    task automatic t_div();
        wr(CTRL, 16'h2); wr(MODE, 16'h0004); wr(CTRL, 16'h3);
        step(15); rdchk("R4 div before", CNT, 16'd0);
        step(1);  rdchk("R4 div first", CNT, 16'd1);
        step(16); rdchk("R4 div second", CNT, 16'd2);
    endtask

    task automatic t_pin();
        wr(CTRL, 16'h2); wr(MODE, 16'h0006); wr(CTRL, 16'h3);
        step(3); rdchk("R4 pin idle", CNT, 16'd0);
        tin_i = 1'b0;
        step(2); rdchk("R4 pin sync delay", CNT, 16'd0);
        step(1); rdchk("R4 pin fall", CNT, 16'd1);
        tin_i = 1'b1;
        step(4); rdchk("R4 pin rise ignored", CNT, 16'd1);
        tin_i = 1'b0;
        step(3); rdchk("R4 pin second fall", CNT, 16'd2);
    endtask

    task automatic t_casc();
        wr(CTRL, 16'h2); wr(MODE, 16'h0000); wr(CTRL, 16'h3);
        step(3); rdchk("R4 casc idle", CNT, 16'd0);
        casc_pulse(); casc_pulse(); casc_pulse();
        rdchk("R4 casc three", CNT, 16'd3);
    endtask

    task automatic t_capture();
        wr(EVT, 16'h3); wr(MODE, 16'h0040);
        tin_i = 1'b1;
        step(2); rdchk("R8 not yet", EVT, 16'd0);
        step(1); rdchk("R8 rise cap", CAP, 16'd3); rdchk("R8 rise flag", EVT, 16'd2);
        chk("R9 cap irq", {15'd0, irq_o}, 16'd1);
        wr(EVT, 16'h3); tin_i = 1'b0;
        step(4); rdchk("R8 fall ignored 01", EVT, 16'd0); rdchk("R8 cap kept", CAP, 16'd3);
        wr(MODE, 16'h0080); casc_pulse(); tin_i = 1'b1;
        step(4); rdchk("R8 rise ignored 10", EVT, 16'd0);
        tin_i = 1'b0;
        step(3); rdchk("R8 fall cap", CAP, 16'd4);
        wr(MODE, 16'h00C0); casc_pulse(); tin_i = 1'b1;
        step(3); rdchk("R8 both rise", CAP, 16'd5);
        casc_pulse(); tin_i = 1'b0;
        step(3); rdchk("R8 both fall", CAP, 16'd6);
        wr(MODE, 16'h0000); wr(EVT, 16'h3); casc_pulse(); tin_i = 1'b1;
        step(4); rdchk("R8 off cap", CAP, 16'd6); rdchk("R8 off flag", EVT, 16'd0);
        chk("R9 no irq", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_gate();
        wr(CTRL, 16'h2); wr(MODE, 16'h0003); wr(CTRL, 16'h1);
        step(5); rdchk("R10 gated off", CNT, 16'd0);
        gate_n_i = 1'b0;
        step(2); rdchk("R10 gate sync", CNT, 16'd0);
        step(2); rdchk("R10 gate open", CNT, 16'd2);
        gate_n_i = 1'b1;
        step(2); rdchk("R10 closing", CNT, 16'd4);
        step(3); rdchk("R10 closed", CNT, 16'd4);
        wr(MODE, 16'h0002);
        step(3); rdchk("R10 gate ignored", CNT, 16'd7);
        wr(CTRL, 16'h0); rdchk("R11 last tick", CNT, 16'd8);
        step(5); rdchk("R11 disabled", CNT, 16'd8);
        rdchk("R11 ctrl read", CTRL, 16'd0);
        wr(CTRL, 16'h2); rdchk("R11 reset counter", CNT, 16'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_vec++; n_bad++;
                $display("FAIL watchdog act=%0d exp=done", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_prescale();
        t_restart();
        t_freerun();
        t_div();
        t_pin();
        t_casc();
        t_capture();
        t_gate();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule